// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the device-side timing engine for synchronous burst reads on a 32-bit memory port. A read begins when the host pulses the active-low address strobe. The block latches the word address and waits a programmable number of clocks. It then presents one 32-bit word per clock, walking linearly through the aligned group of four words that holds the start address and wrapping inside that group. An active-low end-of-burst flag marks one beat in every pass through the group. A configuration bit chooses whether the flag lands on the final beat of the pass or on the beat before it.

The storage array is not part of the block. Each beat's data word is a fixed arithmetic function of its word address, so the host side can check every word it receives. A pass through the group repeats for as long as output enable stays low. Raising chip enable ends a burst at once.

Top module: `burst_rd_seq`

## Requirements
- R1: While reset is high, and after it is released with no strobe, `dvalid` is 0 and `ind_n` is 1.
- R2: In idle with `ce_n` low, the first rising clock edge that samples `adv_n` low is the start edge, and `addr` at that edge is the burst's base word address.
- R3: A low pulse on `adv_n` that no clock edge samples still starts a burst. The base is `addr` at the strobe's rising edge, and the start edge is the first clock edge after that rise.
- R4: For `lat_code` values 1 to 7 the access delay N is `lat_code`+2 clocks. `dvalid` rises on the clock edge N-1 edges after the start edge, so the host samples the first word at edge N.
- R5: Every other `lat_code` value (0 and 8 to 15) gives the delay of code 1, which is N=3.
- R6: Beat k (counted from 0) carries word address {base[AW-1:2], (base[1:0]+k) mod 4}. The address advances by one beat per clock while `dvalid` is high.
- R7: `beat_data` equals (32-bit zero-extended `beat_addr` × 0x9E3779B1, truncated to 32 bits) XOR 0xA5A50F0F whenever `dvalid` is high.
- R8: `ind_n` is low for exactly one clock in each pass of four beats. It is low on beat position 3 of the pass when `ind_early`=0, and on position 2 when `ind_early`=1. Position is k mod 4. `ind_n` is never low while `dvalid` is low.
- R9: At the edge that ends position 3 of a pass, the burst continues into a new pass if `oe_n` is low. If `oe_n` is high there, `dvalid` falls at that edge. At other edges `oe_n` has no effect.
- R10: A clock edge that samples `ce_n` high, in any state, clears `dvalid`, sets `ind_n` and returns the block to idle, where a later strobe starts a new burst.
- R11: A strobe whose low level has already started a burst does not start a second burst when it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; all outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low; high aborts |
| adv_n | input | 1 | Address-valid strobe, active low |
| oe_n | input | 1 | Output enable, active low; high at a pass end stops the burst |
| addr | input | AW | Start word address |
| lat_code | input | 4 | Initial access delay code |
| ind_early | input | 1 | 1: flag on position 2, 0: flag on position 3 |
| dvalid | output | 1 | A beat is presented |
| beat_addr | output | AW | Word address of the current beat |
| beat_data | output | 32 | Data word of the current beat |
| ind_n | output | 1 | End-of-burst flag, active low |

## Verification
A wrong delay count shifts the first `dvalid` by whole clocks, and the error is visible on the first beat of every burst. A corrupted position or base register shows up on the next beat as an address outside the aligned group or a word that does not match its address. A wrong position also moves the `ind_n` pulse within the same pass. Mishandled strobe-edge bookkeeping shows up within two clocks of the strobe's rise, either as a burst that never starts or as a second, unrequested burst.

// File: rtl/bseq_pkg.sv
`timescale 1ns/1ps
package bseq_pkg;
  localparam int DATA_W      = 32;
  localparam int LAT_CODE_W  = 4;
  localparam int LAT_CODE_LO = 1;
  localparam int LAT_CODE_HI = 7;
  localparam int LAT_ADD     = 2;
  localparam int LAT_CNT_W   = $clog2(LAT_CODE_HI + LAT_ADD + 1);

  typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_BEAT} seq_state_e;

  // Stand-in for the storage array: a fixed scramble of the word address.
  function automatic logic [DATA_W-1:0] word_of(input logic [DATA_W-1:0] a);
    logic [DATA_W-1:0] p;
    p = a * 32'h9E37_79B1;
    return p ^ 32'hA5A5_0F0F;
  endfunction

  // Access delay in clocks; undefined codes take the shortest setting.
  function automatic int unsigned lat_cycles(input logic [LAT_CODE_W-1:0] c);
    if (int'(c) >= LAT_CODE_LO && int'(c) <= LAT_CODE_HI)
      return int'(c) + LAT_ADD;
    return LAT_CODE_LO + LAT_ADD;
  endfunction
endpackage

// File: rtl/bseq_adv_capture.sv
`timescale 1ns/1ps
// Catches the rising edge of the address strobe: the address at that
// instant is stored and a toggle flips so the clock domain sees the event.
module bseq_adv_capture #(
  parameter int AW = 20
) (
  input  logic          rst,
  input  logic          adv_n,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] cap_addr,
  output logic          cap_tgl
);
  always_ff @(posedge adv_n or posedge rst) begin
    if (rst) begin
      cap_tgl  <= 1'b0;
      cap_addr <= '0;
    end else begin
      cap_tgl  <= ~cap_tgl;
      cap_addr <= addr;
    end
  end
endmodule

// File: rtl/bseq_lat_timer.sv
`timescale 1ns/1ps
// Down-counter for the initial access delay. Loaded on the start edge with
// N-2, so that expired is seen on the edge N-1 edges after the start edge.
module bseq_lat_timer
  import bseq_pkg::*;
#(
  parameter int CNT_W = LAT_CNT_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [LAT_CODE_W-1:0] code,
  output logic                  expired
);
  logic [CNT_W-1:0] cnt;
  int unsigned      load_val;

  always_comb load_val = lat_cycles(code) - LAT_ADD;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= CNT_W'(load_val);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R5: even the shortest or an undefined code leaves at least one wait clock
  p_lat_floor_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> !expired);
  // R4: the count only ever moves downwards by one
  p_lat_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!load && !expired) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/bseq_beat_gen.sv
`timescale 1ns/1ps
// Holds the burst base and position and drives the registered beat address
// and data word, wrapping inside the aligned group.
module bseq_beat_gen
  import bseq_pkg::*;
#(
  parameter int AW        = 20,
  parameter int BURST_LEN = 4,
  localparam int BW       = $clog2(BURST_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [AW-1:0]     start_addr,
  input  logic              enter,
  input  logic              advance,
  output logic [BW-1:0]     pos,
  output logic [BW-1:0]     nx_pos,
  output logic [AW-1:0]     beat_addr,
  output logic [DATA_W-1:0] beat_data
);
  logic [AW-1:0] base;
  logic [AW-1:0] nx_addr;
  logic [BW-1:0] nx_low;

  always_comb begin
    nx_pos  = enter ? '0 : pos + 1'b1;
    nx_low  = base[BW-1:0] + nx_pos;
    nx_addr = {base[AW-1:BW], nx_low};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base      <= '0;
      pos       <= '0;
      beat_addr <= '0;
      beat_data <= '0;
    end else begin
      if (load) base <= start_addr;
      if (enter || advance) begin
        pos       <= nx_pos;
        beat_addr <= nx_addr;
        beat_data <= word_of(DATA_W'(nx_addr));
      end
    end
  end

  // R6: consecutive beats stay in the group and step by one, wrapping
  p_wrap_step_r6: assert property (@(posedge clk) disable iff (rst)
    advance |=> (beat_addr[AW-1:BW] == $past(beat_addr[AW-1:BW])) &&
                (beat_addr[BW-1:0] == BW'($past(beat_addr[BW-1:0]) + 1'b1)));
endmodule

// File: rtl/burst_rd_seq.sv
`timescale 1ns/1ps
module burst_rd_seq
  import bseq_pkg::*;
#(
  parameter int AW        = 20,
  parameter int BURST_LEN = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ce_n,
  input  logic                  adv_n,
  input  logic                  oe_n,
  input  logic [AW-1:0]         addr,
  input  logic [LAT_CODE_W-1:0] lat_code,
  input  logic                  ind_early,
  output logic                  dvalid,
  output logic [AW-1:0]         beat_addr,
  output logic [DATA_W-1:0]     beat_data,
  output logic                  ind_n
);
  localparam int BW = $clog2(BURST_LEN);
  localparam logic [BW-1:0] POS_LAST = BW'(BURST_LEN - 1);
  localparam logic [BW-1:0] POS_PREV = BW'(BURST_LEN - 2);

  seq_state_e    state, state_nx;
  logic [AW-1:0] cap_addr, start_addr;
  logic          cap_tgl, tgl_seen, absorb;
  logic          rise_evt, start_rise, start_clk, start;
  logic          lat_expired, enter, advance;
  logic [BW-1:0] pos, nx_pos, ind_pos;

  bseq_adv_capture #(.AW(AW)) u_cap (
    .rst(rst), .adv_n(adv_n), .addr(addr),
    .cap_addr(cap_addr), .cap_tgl(cap_tgl)
  );

  // Strobe-rise bookkeeping. A rise that follows a clock-started strobe is
  // absorbed; a rise no clock edge saw low starts the burst itself.
  always_comb begin
    rise_evt   = (cap_tgl != tgl_seen);
    start_rise = (state == SQ_IDLE) && !ce_n && rise_evt && !absorb;
    start_clk  = (state == SQ_IDLE) && !ce_n && !adv_n && !start_rise;
    start      = start_rise || start_clk;
    start_addr = start_rise ? cap_addr : addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgl_seen <= 1'b0;
      absorb   <= 1'b0;
    end else begin
      if (rise_evt)       tgl_seen <= cap_tgl;
      if (start_clk)      absorb   <= 1'b1;
      else if (rise_evt)  absorb   <= 1'b0;
    end
  end

  bseq_lat_timer #(.CNT_W(LAT_CNT_W)) u_lat (
    .clk(clk), .rst(rst), .load(start), .code(lat_code),
    .expired(lat_expired)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      SQ_IDLE: if (start) state_nx = SQ_WAIT;
      SQ_WAIT: begin
        if (ce_n)             state_nx = SQ_IDLE;
        else if (lat_expired) state_nx = SQ_BEAT;
      end
      SQ_BEAT: begin
        if (ce_n)                          state_nx = SQ_IDLE;
        else if (pos == POS_LAST && oe_n)  state_nx = SQ_IDLE;
      end
      default: state_nx = SQ_IDLE;
    endcase
    enter   = (state == SQ_WAIT) && (state_nx == SQ_BEAT);
    advance = (state == SQ_BEAT) && (state_nx == SQ_BEAT);
    ind_pos = ind_early ? POS_PREV : POS_LAST;
  end

  bseq_beat_gen #(.AW(AW), .BURST_LEN(BURST_LEN)) u_beat (
    .clk(clk), .rst(rst), .load(start), .start_addr(start_addr),
    .enter(enter), .advance(advance), .pos(pos), .nx_pos(nx_pos),
    .beat_addr(beat_addr), .beat_data(beat_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SQ_IDLE;
      dvalid <= 1'b0;
      ind_n  <= 1'b1;
    end else begin
      state  <= state_nx;
      dvalid <= (state_nx == SQ_BEAT);
      ind_n  <= !((state_nx == SQ_BEAT) && (nx_pos == ind_pos));
    end
  end

  // R10: chip enable high empties the outputs on the next edge
  p_abort_r10: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> (!dvalid && ind_n));
  // R8: the flag is a single-clock pulse
  p_ind_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    !ind_n |=> ind_n);
  // R8: the flag only marks a presented beat
  p_ind_in_beat_r8: assert property (@(posedge clk) disable iff (rst)
    !ind_n |-> dvalid);
  // R9: output enable high at a pass end stops the stream
  p_oe_stop_r9: assert property (@(posedge clk) disable iff (rst)
    (dvalid && pos == POS_LAST && oe_n) |=> !dvalid);
endmodule

// File: tb/burst_rd_seq_bench.sv
`timescale 1ns/1ps
module burst_rd_seq_bench;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst, ce_n, adv_n, oe_n, ind_early;
  logic [AW-1:0] addr;
  logic [3:0]    lat_code;
  logic          dvalid, ind_n;
  logic [AW-1:0] beat_addr;
  logic [31:0]   beat_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  burst_rd_seq #(.AW(AW), .BURST_LEN(4)) u_burst_rd_seq (
    .clk(clk), .rst(rst), .ce_n(ce_n), .adv_n(adv_n), .oe_n(oe_n),
    .addr(addr), .lat_code(lat_code), .ind_early(ind_early),
    .dvalid(dvalid), .beat_addr(beat_addr), .beat_data(beat_data),
    .ind_n(ind_n)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [AW-1:0] a);
    logic [31:0] m;
    m = 32'(a) * 32'h9E37_79B1;
    return m ^ 32'hA5A5_0F0F;
  endfunction

  function automatic int exp_delay(input int code);
    return (code >= 1 && code <= 7) ? code + 2 : 3;
  endfunction

  // One burst; rise_mode selects a strobe that no clock edge sees low.
  task automatic burst(input int code, input bit early, input logic [AW-1:0] base,
                       input bit rise_mode, input int passes);
    int n   = exp_delay(code);
    int tgt = early ? 2 : 3;
    string stag = rise_mode ? "R3" : "R2";
    lat_code  = 4'(code);
    ind_early = early;
    if (rise_mode) begin
      @(posedge clk);
      #1 ce_n = 1'b0; oe_n = 1'b0; addr = base; adv_n = 1'b0;
      #0.6 adv_n = 1'b1;
      #0.3 addr = ~base;
    end else begin
      @(negedge clk);
      ce_n = 1'b0; oe_n = 1'b0; addr = base; adv_n = 1'b0;
    end
    @(posedge clk);  // start edge
    for (int j = 0; j <= n - 1 + 4 * passes; j++) begin
      @(negedge clk);
      if (j < n - 1) begin
        chk($sformatf("R4/R5 dvalid before delay code=%0d j=%0d", code, j), 64'(dvalid), 64'd0);
        chk("R8 ind_n idle during wait", 64'(ind_n), 64'd1);
      end else if (j - (n - 1) < 4 * passes) begin
        int k = j - (n - 1);
        logic [AW-1:0] ea;
        ea = {base[AW-1:2], 2'(base[1:0] + 2'(k))};
        chk($sformatf("R4/R5 dvalid code=%0d beat=%0d", code, k), 64'(dvalid), 64'd1);
        chk($sformatf("%s/R6 beat_addr beat=%0d", stag, k), 64'(beat_addr), 64'(ea));
        chk($sformatf("R7 beat_data beat=%0d", k), 64'(beat_data), 64'(exp_word(ea)));
        chk($sformatf("R8 ind_n early=%0d beat=%0d", early, k), 64'(ind_n),
            64'((k % 4) == tgt ? 0 : 1));
        if (k == 4 * passes - 1) oe_n = 1'b1;
      end else begin
        chk("R9 dvalid low after oe_n high at pass end", 64'(dvalid), 64'd0);
        chk("R9 ind_n high after end", 64'(ind_n), 64'd1);
      end
      if (j == 0 && !rise_mode) begin
        adv_n = 1'b1;
        addr  = ~base;
      end
    end
    oe_n = 1'b0;
    for (int q = 0; q < 3; q++) begin
      @(negedge clk);
      chk("R11 no second burst from strobe rise", 64'(dvalid), 64'd0);
    end
    ce_n = 1'b1;
    oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic abort_case(input int code, input int drop_after);
    @(negedge clk);
    lat_code = 4'(code); ind_early = 1'b0;
    ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b0; addr = 20'h0_1232;
    @(negedge clk);
    adv_n = 1'b1;
    repeat (drop_after) @(negedge clk);
    ce_n = 1'b1;
    for (int q = 0; q < 12; q++) begin
      @(negedge clk);
      chk($sformatf("R10 abort dvalid code=%0d after=%0d", code, drop_after), 64'(dvalid), 64'd0);
      chk("R10 abort ind_n", 64'(ind_n), 64'd1);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      report();
    end
  end

  initial begin
    rst = 1'b1; adv_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    addr = '0; lat_code = 4'd1; ind_early = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 dvalid in reset", 64'(dvalid), 64'd0);
    chk("R1 ind_n in reset", 64'(ind_n), 64'd1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 dvalid after reset", 64'(dvalid), 64'd0);
    chk("R1 ind_n after reset", 64'(ind_n), 64'd1);

    for (int code = 0; code < 16; code++)
      for (int e = 0; e < 2; e++)
        for (int m = 0; m < 2; m++)
          for (int off = 0; off < 4; off++)
            burst(code, e[0], AW'(20'hA_B5C0 + off + 64 * code), m[0], 1 + (off & 1));

    abort_case(7, 2);   // R10 during the wait
    abort_case(1, 3);   // R10 mid-stream
    burst(3, 1'b0, 20'h0_0077, 1'b0, 1);  // R10 idle again, new burst works
    burst(2, 1'b1, 20'h5_5552, 1'b1, 3);  // R9 three passes

    done = 1'b1;
    report();
  end
endmodule